// File: doc/BRIEF.md
# Debug Probe Mode Router

This block is the glue between a USB-to-serial debug bridge, the local microcontroller, a 20-pin external debug header and a virtual serial port. It senses which cables are attached and picks one of three routing modes. In internal mode the bridge debugs the local controller. In debug-out mode the bridge drives an external target through the header. In debug-in mode an external probe on the header reaches the local controller and the bridge is cut off. All sense inputs are synchronized and debounced, so a mode change only takes effect once the input has been steady for a set number of cycles.

In JTAG mode the clock, mode-select, data-in and data-out lines pass through as separate one-way signals. In SWD mode the mode-select line carries the bidirectional data line. The bridge's enable sets its direction. While the bridge releases the line, the line value is returned on the bridge's data input. Trace output can replace UART transmit data on the virtual serial port. Three reset sources are merged into one stretched active-low microcontroller reset. A display reset is also held while the board serves an external target.

Top module: `probe_mode_router`

## Requirements
- R1: `modeCode` uses 00 for internal, 01 for debug out and 10 for debug in; 11 never appears. After reset, and whenever no cable is sensed, the mode is 00.
- R2: With the probe sense high, target sense low and `hostActive` high, the mode becomes 01. `ledDbgOut` is 1 in mode 01 and only then.
- R3: With the probe sense low, the mode becomes 10, whatever the other senses show. In mode 10, `brTdo` is 0 and the local controller's debug inputs come from the header inputs.
- R4: A change on a sense input changes the mode only after the synchronized input has stayed at its new level for DEBOUNCE_CYCLES consecutive cycles; shorter pulses leave the mode unchanged.
- R5: JTAG (`swdMode`=0) routing. In mode 00, bridge TCK/TMS/TDI drive the local controller with TMS enable 1, and `brTdo`=`mcuTdo`. In mode 01, the same signals drive the header with TMS enable 1, and `brTdo`=`hdrTdoIn`. In mode 10, the header inputs drive the local controller, and `hdrTdoOut`=`mcuTdo` with `hdrTdoOe`=1.
- R6: SWD (`swdMode`=1) routing in modes 00 and 01. The active side's TMS enable equals `brDioOe` and its TDI output is 0. `brTdo` is 0 while `brDioOe`=1; otherwise it is the active side's TMS line input (`mcuTmsIn` or `hdrTmsIn`). In mode 10 with SWD, `mcuTmsOe`=1, `mcuTdi`=0 and `hdrTdoOut`=`mcuSwo`.
- R7: `mcuRstN` goes low within a few cycles when `porN` is low, `rstButtonN` is low or `bridgeRstReq` is high.
- R8: After the last reset source is released, `mcuRstN` stays low for at least RST_STRETCH cycles, then goes high.
- R9: `vcpTx` equals `mcuSwo` while `swoEn`=1, and `uartTx` otherwise.
- R10: In mode 01, `displayRstN` is held low. In other modes it follows `mcuRstN`.
- R11: The side that is not in use is idle with all outputs 0: the header outputs in mode 00, the local controller outputs in mode 01, and the header TCK/TMS/TDI outputs in mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| probeSenseN | input | 1 | Header cable-detect, low when an external probe is attached |
| targetSenseN | input | 1 | Target cable sense, low when a target cable is attached |
| hostActive | input | 1 | Bridge reports that a host debugger is driving it |
| swdMode | input | 1 | 1 selects SWD, 0 selects JTAG |
| swoEn | input | 1 | Steer trace onto the virtual serial transmit line |
| rstButtonN | input | 1 | Reset push switch, low while pressed |
| bridgeRstReq | input | 1 | Reset request from the bridge |
| brTck | input | 1 | Bridge debug clock |
| brTms | input | 1 | Bridge TMS / SWD data out |
| brTdi | input | 1 | Bridge TDI |
| brDioOe | input | 1 | Bridge SWD data drive enable |
| brTdo | output | 1 | Data returned to the bridge |
| mcuTck | output | 1 | Local controller debug clock |
| mcuTmsOut | output | 1 | Local controller TMS / SWD data drive value |
| mcuTmsOe | output | 1 | Local controller TMS / SWD data drive enable |
| mcuTmsIn | input | 1 | Local controller TMS / SWD line readback |
| mcuTdi | output | 1 | Local controller TDI |
| mcuTdo | input | 1 | Local controller TDO |
| mcuSwo | input | 1 | Local controller trace output |
| hdrTck | output | 1 | Header debug clock toward the target |
| hdrTmsOut | output | 1 | Header TMS / SWD data drive value |
| hdrTmsOe | output | 1 | Header TMS / SWD data drive enable |
| hdrTdi | output | 1 | Header TDI toward the target |
| hdrTdoOut | output | 1 | Header TDO drive value toward a probe |
| hdrTdoOe | output | 1 | Header TDO drive enable |
| hdrTckIn | input | 1 | Header clock from an external probe |
| hdrTmsIn | input | 1 | Header TMS / SWD line readback |
| hdrTdiIn | input | 1 | Header TDI from an external probe |
| hdrTdoIn | input | 1 | Header TDO from an external target |
| uartTx | input | 1 | Local controller UART transmit |
| vcpTx | output | 1 | Virtual serial port transmit line |
| mcuRstN | output | 1 | Merged, stretched microcontroller reset, active low |
| displayRstN | output | 1 | Display reset, active low |
| ledDbgOut | output | 1 | Debug-out indicator |
| modeCode | output | 2 | Current mode encoding |

## Verification
A wrong mode register shows up on `modeCode` and `ledDbgOut`, and in the routed data outputs, one cycle after it settles. This is about DEBOUNCE_CYCLES plus three cycles after a sense change, so mode checks are taken well after that window. Glitches shorter than the window are applied to show that the mode register holds. A stretch counter that is off shows up as `mcuRstN` rising early or never. It is sampled at half the stretch and again past its end. The routing is combinational from registered selects, so a wrong select or direction term is visible on the same cycle as a random data pattern.

// File: rtl/probe_route_pkg.sv
package probe_route_pkg;

  typedef enum logic [1:0] {
    MODE_INT = 2'b00,
    MODE_OUT = 2'b01,
    MODE_IN  = 2'b10
  } probeMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selInt;
    logic selOut;
    logic selIn;
    logic swd;
  } routeSel_t;

endpackage

// File: rtl/probe_route_sync.sv
module probe_route_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RESET_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/probe_route_ctrl.sv
module probe_route_ctrl
  import probe_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int RST_STRETCH = 32
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       probeSenseN,
  input  logic       targetSenseN,
  input  logic       hostActive,
  input  logic       swdMode,
  input  logic       rstButtonN,
  input  logic       bridgeRstReq,
  output routeSel_t  sel,
  output probeMode_e mode,
  output logic       mcuRstN,
  output logic       displayRstN,
  output logic       ledDbgOut
);
  localparam int NUM_SYNC = 6;
  localparam int NUM_DEB = 3;
  localparam int DB_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int ST_W = $clog2(RST_STRETCH + 1);
  localparam logic [NUM_SYNC-1:0] SYNC_RST = 6'b001011;
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_CYCLES - 1);
  localparam logic [ST_W-1:0] ST_LOAD = ST_W'(RST_STRETCH);

  logic [NUM_SYNC-1:0] rawIn, syncIn;
  logic stable [NUM_DEB];
  probeMode_e modeQ, modeNext;
  logic [ST_W-1:0] stretchCnt;
  logic srcActive, mcuRstNQ, dispRstNQ;

  // bit order: {bridgeRstReq, rstButtonN, swdMode, hostActive, targetSenseN, probeSenseN}
  assign rawIn = {bridgeRstReq, rstButtonN, swdMode, hostActive, targetSenseN, probeSenseN};

  probe_route_sync #(
    .WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)
  ) uSync (
    .clk(clk), .rstN(porN), .din(rawIn), .dout(syncIn)
  );

  // debounce on the three cable / host sense lines
  for (genvar i = 0; i < NUM_DEB; i++) begin : g_deb
    logic [DB_W-1:0] dbCnt;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        dbCnt <= '0;
        stable[i] <= SYNC_RST[i];
      end else if (syncIn[i] == stable[i]) begin
        dbCnt <= '0;
      end else if (dbCnt == DB_LAST) begin
        dbCnt <= '0;
        stable[i] <= syncIn[i];
      end else begin
        dbCnt <= dbCnt + 1'b1;
      end
    end
  end

  // probe has priority over target cable
  always_comb begin
    if (!stable[0])                   modeNext = MODE_IN;
    else if (!stable[1] && stable[2]) modeNext = MODE_OUT;
    else                              modeNext = MODE_INT;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) modeQ <= MODE_INT;
    else       modeQ <= modeNext;
  end

  assign sel.selInt = (modeQ == MODE_INT);
  assign sel.selOut = (modeQ == MODE_OUT);
  assign sel.selIn  = (modeQ == MODE_IN);
  assign sel.swd    = syncIn[3];
  assign mode       = modeQ;
  assign ledDbgOut  = (modeQ == MODE_OUT);

  // reset merge and stretch
  assign srcActive = !syncIn[4] || syncIn[5];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stretchCnt <= ST_LOAD;
      mcuRstNQ   <= 1'b0;
      dispRstNQ  <= 1'b0;
    end else begin
      if (srcActive)             stretchCnt <= ST_LOAD;
      else if (stretchCnt != '0) stretchCnt <= stretchCnt - 1'b1;
      mcuRstNQ  <= !(srcActive || (stretchCnt != '0));
      dispRstNQ <= !(srcActive || (stretchCnt != '0)) && (modeQ != MODE_OUT);
    end
  end

  assign mcuRstN     = mcuRstNQ;
  assign displayRstN = dispRstNQ;

  // checker: cycles since any reset source was last active
  logic [ST_W-1:0] relCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                  relCnt <= '0;
    else if (srcActive)         relCnt <= '0;
    else if (relCnt != ST_LOAD) relCnt <= relCnt + 1'b1;
  end

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!porN)
    modeQ != 2'b11);
  a_r7_src_resets: assert property (@(posedge clk) disable iff (!porN)
    srcActive |=> !mcuRstN);
  a_r8_stretch: assert property (@(posedge clk) disable iff (!porN)
    $rose(mcuRstN) |-> (relCnt == ST_LOAD));
  a_r10_disp_held: assert property (@(posedge clk) disable iff (!porN)
    (modeQ == MODE_OUT) |=> !displayRstN);
endmodule

// File: rtl/probe_route_dp.sv
module probe_route_dp
  import probe_route_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  routeSel_t sel,
  input  logic      swoEn,
  input  logic      brTck,
  input  logic      brTms,
  input  logic      brTdi,
  input  logic      brDioOe,
  output logic      brTdo,
  output logic      mcuTck,
  output logic      mcuTmsOut,
  output logic      mcuTmsOe,
  input  logic      mcuTmsIn,
  output logic      mcuTdi,
  input  logic      mcuTdo,
  input  logic      mcuSwo,
  output logic      hdrTck,
  output logic      hdrTmsOut,
  output logic      hdrTmsOe,
  output logic      hdrTdi,
  output logic      hdrTdoOut,
  output logic      hdrTdoOe,
  input  logic      hdrTckIn,
  input  logic      hdrTmsIn,
  input  logic      hdrTdiIn,
  input  logic      hdrTdoIn,
  input  logic      uartTx,
  output logic      vcpTx
);
  logic bridgeDrive, bridgeBack;

  // direction of the bridge-owned data line
  assign bridgeDrive = sel.swd ? brDioOe : 1'b1;

  always_comb begin
    mcuTck = 1'b0; mcuTmsOut = 1'b0; mcuTmsOe = 1'b0; mcuTdi = 1'b0;
    hdrTck = 1'b0; hdrTmsOut = 1'b0; hdrTmsOe = 1'b0; hdrTdi = 1'b0;
    hdrTdoOut = 1'b0; hdrTdoOe = 1'b0;
    bridgeBack = 1'b0;
    brTdo = 1'b0;
    if (sel.selInt) begin
      mcuTck     = brTck;
      mcuTmsOut  = brTms;
      mcuTmsOe   = bridgeDrive;
      mcuTdi     = sel.swd ? 1'b0 : brTdi;
      bridgeBack = sel.swd ? mcuTmsIn : mcuTdo;
    end else if (sel.selOut) begin
      hdrTck     = brTck;
      hdrTmsOut  = brTms;
      hdrTmsOe   = bridgeDrive;
      hdrTdi     = sel.swd ? 1'b0 : brTdi;
      bridgeBack = sel.swd ? hdrTmsIn : hdrTdoIn;
    end else if (sel.selIn) begin
      mcuTck    = hdrTckIn;
      mcuTmsOut = hdrTmsIn;
      mcuTmsOe  = 1'b1;
      mcuTdi    = sel.swd ? 1'b0 : hdrTdiIn;
      hdrTdoOut = sel.swd ? mcuSwo : mcuTdo;
      hdrTdoOe  = 1'b1;
    end
    if (!sel.selIn) brTdo = (sel.swd && brDioOe) ? 1'b0 : bridgeBack;
  end

  assign vcpTx = swoEn ? mcuSwo : uartTx;

  a_r6_swd_release: assert property (@(posedge clk) disable iff (!rstN)
    (sel.swd && sel.selInt && !brDioOe) |-> !mcuTmsOe);
  a_r11_out_idle: assert property (@(posedge clk) disable iff (!rstN)
    sel.selOut |-> (!mcuTck && !mcuTmsOe && !mcuTdi));
  a_r3_bridge_cut: assert property (@(posedge clk) disable iff (!rstN)
    sel.selIn |-> (!brTdo && !hdrTmsOe));
  a_r1_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sel.selInt, sel.selOut, sel.selIn}));
endmodule

// File: rtl/probe_mode_router.sv
module probe_mode_router
  import probe_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int RST_STRETCH = 32
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       probeSenseN,
  input  logic       targetSenseN,
  input  logic       hostActive,
  input  logic       swdMode,
  input  logic       swoEn,
  input  logic       rstButtonN,
  input  logic       bridgeRstReq,
  input  logic       brTck,
  input  logic       brTms,
  input  logic       brTdi,
  input  logic       brDioOe,
  output logic       brTdo,
  output logic       mcuTck,
  output logic       mcuTmsOut,
  output logic       mcuTmsOe,
  input  logic       mcuTmsIn,
  output logic       mcuTdi,
  input  logic       mcuTdo,
  input  logic       mcuSwo,
  output logic       hdrTck,
  output logic       hdrTmsOut,
  output logic       hdrTmsOe,
  output logic       hdrTdi,
  output logic       hdrTdoOut,
  output logic       hdrTdoOe,
  input  logic       hdrTckIn,
  input  logic       hdrTmsIn,
  input  logic       hdrTdiIn,
  input  logic       hdrTdoIn,
  input  logic       uartTx,
  output logic       vcpTx,
  output logic       mcuRstN,
  output logic       displayRstN,
  output logic       ledDbgOut,
  output logic [1:0] modeCode
);
  routeSel_t  sel;
  probeMode_e mode;

  probe_route_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES), .RST_STRETCH(RST_STRETCH)
  ) uCtrl (
    .clk(clk), .porN(porN), .probeSenseN(probeSenseN), .targetSenseN(targetSenseN),
    .hostActive(hostActive), .swdMode(swdMode), .rstButtonN(rstButtonN),
    .bridgeRstReq(bridgeRstReq), .sel(sel), .mode(mode), .mcuRstN(mcuRstN),
    .displayRstN(displayRstN), .ledDbgOut(ledDbgOut)
  );

  probe_route_dp uDp (
    .clk(clk), .rstN(porN), .sel(sel), .swoEn(swoEn),
    .brTck(brTck), .brTms(brTms), .brTdi(brTdi), .brDioOe(brDioOe), .brTdo(brTdo),
    .mcuTck(mcuTck), .mcuTmsOut(mcuTmsOut), .mcuTmsOe(mcuTmsOe), .mcuTmsIn(mcuTmsIn),
    .mcuTdi(mcuTdi), .mcuTdo(mcuTdo), .mcuSwo(mcuSwo),
    .hdrTck(hdrTck), .hdrTmsOut(hdrTmsOut), .hdrTmsOe(hdrTmsOe), .hdrTdi(hdrTdi),
    .hdrTdoOut(hdrTdoOut), .hdrTdoOe(hdrTdoOe), .hdrTckIn(hdrTckIn), .hdrTmsIn(hdrTmsIn),
    .hdrTdiIn(hdrTdiIn), .hdrTdoIn(hdrTdoIn), .uartTx(uartTx), .vcpTx(vcpTx)
  );

  assign modeCode = mode;
endmodule

// File: tb/probe_mode_router_test.sv
module probe_mode_router_test;
  localparam int DEB = 16;
  localparam int STR = 32;

  logic clk = 0;
  always #5 clk = ~clk;

  logic porN, probeSenseN, targetSenseN, hostActive, swdMode, swoEn, rstButtonN, bridgeRstReq;
  logic brTck, brTms, brTdi, brDioOe, brTdo;
  logic mcuTck, mcuTmsOut, mcuTmsOe, mcuTmsIn, mcuTdi, mcuTdo, mcuSwo;
  logic hdrTck, hdrTmsOut, hdrTmsOe, hdrTdi, hdrTdoOut, hdrTdoOe;
  logic hdrTckIn, hdrTmsIn, hdrTdiIn, hdrTdoIn, uartTx, vcpTx;
  logic mcuRstN, displayRstN, ledDbgOut;
  logic [1:0] modeCode;

  probe_mode_router #(.DEBOUNCE_CYCLES(DEB), .RST_STRETCH(STR)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // {mcuTck,mcuTmsOut,mcuTmsOe,mcuTdi,hdrTck,hdrTmsOut,hdrTmsOe,hdrTdi,hdrTdoOut,hdrTdoOe,brTdo,vcpTx}
  function automatic logic [11:0] expRoute(input logic [1:0] m, input logic s);
    logic mT = 0, mS = 0, mO = 0, mD = 0, hT = 0, hS = 0, hO = 0, hD = 0, hQ = 0, hQo = 0, bQ = 0, v;
    v = swoEn ? mcuSwo : uartTx;
    case (m)
      2'b00: begin
        mT = brTck; mS = brTms; mO = s ? brDioOe : 1'b1; mD = s ? 1'b0 : brTdi;
        bQ = s ? (brDioOe ? 1'b0 : mcuTmsIn) : mcuTdo;
      end
      2'b01: begin
        hT = brTck; hS = brTms; hO = s ? brDioOe : 1'b1; hD = s ? 1'b0 : brTdi;
        bQ = s ? (brDioOe ? 1'b0 : hdrTmsIn) : hdrTdoIn;
      end
      default: begin
        mT = hdrTckIn; mS = hdrTmsIn; mO = 1'b1; mD = s ? 1'b0 : hdrTdiIn;
        hQ = s ? mcuSwo : mcuTdo; hQo = 1'b1;
      end
    endcase
    return {mT, mS, mO, mD, hT, hS, hO, hD, hQ, hQo, bQ, v};
  endfunction

  function automatic logic [1:0] expMode(input logic p, input logic t, input logic h);
    if (!p) return 2'b10;
    if (!t && h) return 2'b01;
    return 2'b00;
  endfunction

  task automatic randData();
    {brTck, brTms, brTdi, brDioOe, mcuTmsIn, mcuTdo, mcuSwo} = 7'($urandom);
    {hdrTckIn, hdrTmsIn, hdrTdiIn, hdrTdoIn, uartTx, swoEn} = 6'($urandom);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] combos [6];
    void'($urandom(32'd4242));
    porN = 0; probeSenseN = 1; targetSenseN = 1; hostActive = 0; swdMode = 0; swoEn = 0;
    rstButtonN = 1; bridgeRstReq = 0;
    randData();
    #23;
    chk("R7 reset state mcuRstN", mcuRstN, 0);
    chk("R1 reset mode", modeCode, 2'b00);
    chk("R2 reset led", ledDbgOut, 0);
    @(negedge clk); porN = 1;
    step(STR / 2);
    chk("R8 stretch after POR", mcuRstN, 0);
    step(STR + 8);
    chk("R8 release after POR", mcuRstN, 1);
    chk("R1 idle mode", modeCode, 2'b00);

    // {probeSenseN, targetSenseN, hostActive}
    combos[0] = 3'b111; combos[1] = 3'b101; combos[2] = 3'b100;
    combos[3] = 3'b001; combos[4] = 3'b010; combos[5] = 3'b101;
    foreach (combos[c]) begin
      logic [1:0] em;
      {probeSenseN, targetSenseN, hostActive} = combos[c];
      em = expMode(combos[c][2], combos[c][1], combos[c][0]);
      step(DEB + 10);
      chk(em == 2'b10 ? "R3 mode" : (em == 2'b01 ? "R2 mode" : "R1 mode"), modeCode, em);
      chk("R2 led", ledDbgOut, em == 2'b01);
      chk("R10 display reset", displayRstN, em != 2'b01);
      for (int s = 0; s < 2; s++) begin
        swdMode = s[0];
        step(6);
        for (int k = 0; k < 12; k++) begin
          randData();
          #1;
          chk(s ? "R6 R11 swd route" : "R5 R11 jtag route",
              {mcuTck, mcuTmsOut, mcuTmsOe, mcuTdi, hdrTck, hdrTmsOut, hdrTmsOe, hdrTdi,
               hdrTdoOut, hdrTdoOe, brTdo, vcpTx}, expRoute(em, s[0]));
        end
      end
    end

    // R9 directed
    swoEn = 1; mcuSwo = 1; uartTx = 0; #1; chk("R9 swo steered", vcpTx, 1);
    swoEn = 0; #1; chk("R9 uart restored", vcpTx, 0);

    // R6 directed: release and readback in internal mode
    {probeSenseN, targetSenseN, hostActive} = 3'b110;
    swdMode = 1;
    step(DEB + 10);
    chk("R1 back to internal", modeCode, 2'b00);
    brDioOe = 0; mcuTmsIn = 1; #1;
    chk("R6 released oe", mcuTmsOe, 0);
    chk("R6 readback", brTdo, 1);
    brDioOe = 1; #1;
    chk("R6 driving oe", mcuTmsOe, 1);
    chk("R6 no readback", brTdo, 0);

    // R4 debounce
    @(negedge clk); probeSenseN = 0;
    step(4);
    probeSenseN = 1;
    step(30);
    chk("R4 short glitch ignored", modeCode, 2'b00);
    probeSenseN = 0;
    step(8);
    chk("R4 not yet taken", modeCode, 2'b00);
    step(20);
    chk("R4 taken after stable", modeCode, 2'b10);
    probeSenseN = 1;
    step(DEB + 10);

    // R7/R8 button and bridge request
    chk("R8 still released", mcuRstN, 1);
    rstButtonN = 0; step(5);
    chk("R7 button resets", mcuRstN, 0);
    rstButtonN = 1; step(STR / 2);
    chk("R8 button stretch", mcuRstN, 0);
    step(STR + 8);
    chk("R8 button release", mcuRstN, 1);
    bridgeRstReq = 1; step(5);
    chk("R7 bridge resets", mcuRstN, 0);
    chk("R7 display follows", displayRstN, 0);
    bridgeRstReq = 0; step(STR - 4);
    chk("R8 bridge stretch", mcuRstN, 0);
    step(16);
    chk("R8 bridge release", mcuRstN, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule